// File: doc/BRIEF.md
# RV32I Instruction Decoder for Datapath Control

This block turns one 32-bit RV32I instruction word into the steering signals of a simple datapath. It extracts the register indices, builds a sign-extended immediate, and selects what feeds each ALU operand and what is written back. It also raises the register write enable and the memory read and write strobes.

It handles loads, stores, register-immediate and register-register arithmetic, conditional branches, LUI, AUIPC, JAL and JALR. The ALU function code is produced elsewhere, and system or CSR instructions are not decoded. The block is purely combinational: every output is a function of the current instruction word alone and follows it within the same cycle.

LUI is treated as x0 plus the upper immediate, so the ALU performs the same addition as for every other immediate form. Branches and JAL use the ALU to form PC plus offset. The link value PC+4 reaches the register file through a dedicated write-back choice.

Top module: `rv32_ctrl_decoder`

## Requirements
- R1: Select encodings are fixed: op1_pc_o 0 picks the first register read value and 1 the instruction address; op2_imm_o 0 picks the second register read value and 1 the immediate; wb_sel_o 00 is ALU result, 01 memory read data, 10 PC+4, and 11 is never driven.
- R2: A load (opcode bits [6:0] = 0000011) gives op1 register, op2 immediate, write-back 01, register write on, memory read on, memory write off, and the I-format immediate.
- R3: A store (0100011) gives op1 register, op2 immediate, memory write on, memory read off, register write off, and the S-format immediate.
- R4: A register-immediate operation (0010011) gives op1 register, op2 immediate, write-back 00, register write on, no memory access, and the I-format immediate.
- R5: A register-register operation (0110011) gives both operands from registers, write-back 00, register write on, no memory access, and an immediate of zero.
- R6: A conditional branch (1100011) gives op1 PC, op2 immediate, register write off, no memory access, and the B-format immediate.
- R7: LUI (0110111) gives op1 register with rs1 index forced to 0, op2 immediate, write-back 00, register write on, and an immediate equal to bits [31:12] shifted left by 12.
- R8: AUIPC (0010111) gives op1 PC, op2 immediate, write-back 00, register write on, and the same upper immediate as LUI.
- R9: JAL (1101111) gives op1 PC, op2 immediate, write-back 10, register write on, and the J-format immediate.
- R10: JALR (1100111) gives op1 register, op2 immediate, write-back 10, register write on, and the I-format immediate.
- R11: Any other opcode value drives every enable and select low, every index to 0 and the immediate to 0.
- R12: rs1_idx_o is bits [19:15] for load, store, register-immediate, register-register, branch and JALR, else 0; rs2_idx_o is bits [24:20] for store, register-register and branch, else 0; rd_idx_o is bits [11:7] whenever register write is on, else 0.
- R13: Every immediate is sign-extended from instruction bit 31; the B and J formats always have bit 0 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word being decoded |
| rs1_idx_o | output | 5 | First source register index |
| rs2_idx_o | output | 5 | Second source register index |
| rd_idx_o | output | 5 | Destination register index |
| imm_o | output | XLEN | Sign-extended immediate |
| op1_pc_o | output | 1 | ALU operand 1 select: 0 register, 1 PC |
| op2_imm_o | output | 1 | ALU operand 2 select: 0 register, 1 immediate |
| wb_sel_o | output | 2 | Write-back source: 00 ALU, 01 memory, 10 PC+4 |
| reg_we_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read enable |
| mem_wr_o | output | 1 | Data memory write enable |

## Verification
The embedded assertions take for granted that the instruction word carries only 0 and 1 values; they are skipped while any bit is unknown, since a word with X bits has no defined decode. The stimulus respects this by driving fully known words only: hand-encoded instructions with positive and negative offsets, pseudo-random words whose opcode field is forced onto each supported value, and unconstrained random words that almost always land on unsupported opcodes. A behavioural model in the bench predicts every output for each word, and the outputs are compared one cycle at a time.

// File: rtl/rv_dec_pkg.sv
// Package: shared opcode values, select encodings and the internal
// control bundle of the RV32I decoder. Assumes 7-bit major opcodes.
package rv_dec_pkg;

    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;

    typedef enum logic [1:0] {
        WB_ALU = 2'b00,
        WB_MEM = 2'b01,
        WB_PC4 = 2'b10
    } wb_sel_e;

    typedef enum logic [2:0] {
        FMT_NONE = 3'd0,
        FMT_I    = 3'd1,
        FMT_S    = 3'd2,
        FMT_B    = 3'd3,
        FMT_U    = 3'd4,
        FMT_J    = 3'd5
    } imm_fmt_e;

    typedef struct packed {
        logic      op1_pc;
        logic      op2_imm;
        wb_sel_e   wb_sel;
        logic      reg_we;
        logic      mem_rd;
        logic      mem_wr;
        logic      use_rs1;
        logic      use_rs2;
        imm_fmt_e  fmt;
    } ctrl_t;

endpackage

// File: rtl/rv_ctrl_decode.sv
// Module: maps the major opcode onto the control bundle.
// Assumes: only the 7-bit opcode matters; unknown opcodes give an all-zero bundle.
module rv_ctrl_decode
    import rv_dec_pkg::*;
(
    input  logic [6:0] opcode_i,
    output ctrl_t      ctrl_o
);

    // Control table: one row per supported opcode, zero otherwise
    always_comb begin
        ctrl_o = '0;
        case (opcode_i)
            OPC_LOAD: begin
                ctrl_o.op2_imm = 1'b1;
                ctrl_o.wb_sel  = WB_MEM;
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.mem_rd  = 1'b1;
                ctrl_o.use_rs1 = 1'b1;
                ctrl_o.fmt     = FMT_I;
            end
            OPC_STORE: begin
                ctrl_o.op2_imm = 1'b1;
                ctrl_o.mem_wr  = 1'b1;
                ctrl_o.use_rs1 = 1'b1;
                ctrl_o.use_rs2 = 1'b1;
                ctrl_o.fmt     = FMT_S;
            end
            OPC_OPIMM: begin
                ctrl_o.op2_imm = 1'b1;
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.use_rs1 = 1'b1;
                ctrl_o.fmt     = FMT_I;
            end
            OPC_OP: begin
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.use_rs1 = 1'b1;
                ctrl_o.use_rs2 = 1'b1;
            end
            OPC_BRANCH: begin
                ctrl_o.op1_pc  = 1'b1;
                ctrl_o.op2_imm = 1'b1;
                ctrl_o.use_rs1 = 1'b1;
                ctrl_o.use_rs2 = 1'b1;
                ctrl_o.fmt     = FMT_B;
            end
            OPC_LUI: begin
                ctrl_o.op2_imm = 1'b1;
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.fmt     = FMT_U;
            end
            OPC_AUIPC: begin
                ctrl_o.op1_pc  = 1'b1;
                ctrl_o.op2_imm = 1'b1;
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.fmt     = FMT_U;
            end
            OPC_JAL: begin
                ctrl_o.op1_pc  = 1'b1;
                ctrl_o.op2_imm = 1'b1;
                ctrl_o.wb_sel  = WB_PC4;
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.fmt     = FMT_J;
            end
            OPC_JALR: begin
                ctrl_o.op2_imm = 1'b1;
                ctrl_o.wb_sel  = WB_PC4;
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.use_rs1 = 1'b1;
                ctrl_o.fmt     = FMT_I;
            end
            default: ctrl_o = '0;
        endcase
    end

    // Memory strobes are mutually exclusive and a load always writes back memory data
    always_comb begin
        if (!$isunknown(opcode_i)) begin
            // R1
            mem_excl_chk: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr))
                else $error("memory read and write both raised");
            // R2
            load_wb_chk: assert (!ctrl_o.mem_rd || (ctrl_o.wb_sel == WB_MEM && ctrl_o.reg_we))
                else $error("memory read without memory write-back");
        end
    end

endmodule

// File: rtl/rv_imm_build.sv
// Module: assembles the immediate for the format chosen by the control table.
// Assumes: XLEN >= 32; sign always comes from instruction bit 31.
module rv_imm_build
    import rv_dec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:7]     bits_i,
    input  imm_fmt_e        fmt_i,
    output logic [XLEN-1:0] imm_o
);

    localparam int EXT_W = XLEN - 32;

    logic        sgn;
    logic [31:0] imm32;

    assign sgn = bits_i[31];

    // Format mux: gather the scattered immediate fields into 32 bits
    always_comb begin
        case (fmt_i)
            FMT_I:   imm32 = {{20{sgn}}, bits_i[31:20]};
            FMT_S:   imm32 = {{20{sgn}}, bits_i[31:25], bits_i[11:7]};
            FMT_B:   imm32 = {{19{sgn}}, sgn, bits_i[7], bits_i[30:25], bits_i[11:8], 1'b0};
            FMT_U:   imm32 = {bits_i[31:12], 12'h000};
            FMT_J:   imm32 = {{11{sgn}}, sgn, bits_i[19:12], bits_i[20], bits_i[30:21], 1'b0};
            default: imm32 = '0;
        endcase
    end

    // Width variant: widen to XLEN only when the datapath is wider than 32
    generate
        if (EXT_W > 0) begin : g_wide
            assign imm_o = {{EXT_W{imm32[31]}}, imm32};
        end else begin : g_narrow
            assign imm_o = imm32;
        end
    endgenerate

endmodule

// File: rtl/rv_reg_fields.sv
// Module: passes register index fields through only when the instruction uses them.
// Assumes: unused indices are reported as x0.
module rv_reg_fields (
    input  logic [4:0] rs1_f_i,
    input  logic [4:0] rs2_f_i,
    input  logic [4:0] rd_f_i,
    input  logic       use_rs1_i,
    input  logic       use_rs2_i,
    input  logic       use_rd_i,
    output logic [4:0] rs1_idx_o,
    output logic [4:0] rs2_idx_o,
    output logic [4:0] rd_idx_o
);

    // Index gating: unused fields read as register 0
    always_comb begin
        rs1_idx_o = use_rs1_i ? rs1_f_i : 5'd0;
        rs2_idx_o = use_rs2_i ? rs2_f_i : 5'd0;
        rd_idx_o  = use_rd_i  ? rd_f_i  : 5'd0;
    end

endmodule

// File: rtl/rv32_ctrl_decoder.sv
// Module: top of the RV32I decoder; combines control table, immediate builder
// and index gating. Assumes: a fully known instruction word; no state, no clock.
module rv32_ctrl_decoder
    import rv_dec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr_i,
    output logic [4:0]      rs1_idx_o,
    output logic [4:0]      rs2_idx_o,
    output logic [4:0]      rd_idx_o,
    output logic [XLEN-1:0] imm_o,
    output logic            op1_pc_o,
    output logic            op2_imm_o,
    output logic [1:0]      wb_sel_o,
    output logic            reg_we_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o
);

    ctrl_t ctrl;
    logic  unused_funct3;
    logic  known_opc;

    assign unused_funct3 = ^instr_i[14:12];

    rv_ctrl_decode u_ctrl (
        .opcode_i (instr_i[6:0]),
        .ctrl_o   (ctrl)
    );

    rv_imm_build #(.XLEN(XLEN)) u_imm (
        .bits_i (instr_i[31:7]),
        .fmt_i  (ctrl.fmt),
        .imm_o  (imm_o)
    );

    rv_reg_fields u_idx (
        .rs1_f_i   (instr_i[19:15]),
        .rs2_f_i   (instr_i[24:20]),
        .rd_f_i    (instr_i[11:7]),
        .use_rs1_i (ctrl.use_rs1),
        .use_rs2_i (ctrl.use_rs2),
        .use_rd_i  (ctrl.reg_we),
        .rs1_idx_o (rs1_idx_o),
        .rs2_idx_o (rs2_idx_o),
        .rd_idx_o  (rd_idx_o)
    );

    // Output drive: flatten the control bundle onto the ports
    always_comb begin
        op1_pc_o  = ctrl.op1_pc;
        op2_imm_o = ctrl.op2_imm;
        wb_sel_o  = ctrl.wb_sel;
        reg_we_o  = ctrl.reg_we;
        mem_rd_o  = ctrl.mem_rd;
        mem_wr_o  = ctrl.mem_wr;
    end

    // Opcode membership test used only by the checks below
    always_comb begin
        case (instr_i[6:0])
            OPC_LOAD, OPC_STORE, OPC_OPIMM, OPC_OP, OPC_BRANCH,
            OPC_LUI, OPC_AUIPC, OPC_JAL, OPC_JALR: known_opc = 1'b1;
            default:                                known_opc = 1'b0;
        endcase
    end

    // Cross-unit checks between the control table, immediate and index paths
    always_comb begin
        if (!$isunknown(instr_i)) begin
            // R1
            wb_code_chk: assert (wb_sel_o != 2'b11)
                else $error("reserved write-back code driven");
            // R3
            store_quiet_chk: assert (!mem_wr_o || (!reg_we_o && !mem_rd_o && rd_idx_o == 5'd0))
                else $error("store also writes a register");
            // R5
            reg_op2_imm_chk: assert (op2_imm_o || imm_o == '0)
                else $error("immediate nonzero with register operand 2");
            // R7
            lui_x0_chk: assert (instr_i[6:0] != OPC_LUI || (rs1_idx_o == 5'd0 && !op1_pc_o))
                else $error("LUI not mapped to x0 plus immediate");
            // R11
            unknown_quiet_chk: assert (known_opc ||
                (!op1_pc_o && !op2_imm_o && wb_sel_o == 2'b00 && !reg_we_o && !mem_rd_o &&
                 !mem_wr_o && rs1_idx_o == 5'd0 && rs2_idx_o == 5'd0 && imm_o == '0))
                else $error("unsupported opcode left outputs active");
            // R12
            rd_gate_chk: assert (reg_we_o || rd_idx_o == 5'd0)
                else $error("destination index without write enable");
            // R13
            pc_imm_even_chk: assert (!op1_pc_o || !imm_o[0])
                else $error("odd offset added to PC");
        end
    end

endmodule

// File: tb/rv32_ctrl_decoder_test.sv
`timescale 1ns/1ps
module rv32_ctrl_decoder_test;

    logic        clk = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [4:0]  rs1_idx, rs2_idx, rd_idx;
    logic [31:0] imm;
    logic        op1_pc, op2_imm, reg_we, mem_rd, mem_wr;
    logic [1:0]  wb_sel;

    int total = 0;
    int bad   = 0;

    typedef struct packed {
        logic        op1;
        logic        op2;
        logic [1:0]  wb;
        logic        we;
        logic        mrd;
        logic        mwr;
        logic [4:0]  rs1;
        logic [4:0]  rs2;
        logic [4:0]  rd;
        logic [31:0] imm;
    } exp_t;

    always #2.5 clk = ~clk;

    rv32_ctrl_decoder #(.XLEN(32)) uut (
        .instr_i   (instr),
        .rs1_idx_o (rs1_idx),
        .rs2_idx_o (rs2_idx),
        .rd_idx_o  (rd_idx),
        .imm_o     (imm),
        .op1_pc_o  (op1_pc),
        .op2_imm_o (op2_imm),
        .wb_sel_o  (wb_sel),
        .reg_we_o  (reg_we),
        .mem_rd_o  (mem_rd),
        .mem_wr_o  (mem_wr)
    );

    function automatic string req_of(logic [6:0] op);
        case (op)
            7'b0000011: return "R2";
            7'b0100011: return "R3";
            7'b0010011: return "R4";
            7'b0110011: return "R5";
            7'b1100011: return "R6";
            7'b0110111: return "R7";
            7'b0010111: return "R8";
            7'b1101111: return "R9";
            7'b1100111: return "R10";
            default:    return "R11";
        endcase
    endfunction

    // Behavioural reference built from the requirement text
    function automatic exp_t model(logic [31:0] w);
        exp_t e;
        logic signed [31:0] iv, sv, bv, jv;
        logic [31:0] uv;
        bit rd1, rd2;
        iv = $signed(w[31:20]);
        sv = $signed({w[31:25], w[11:7]});
        bv = $signed({w[31], w[7], w[30:25], w[11:8], 1'b0});
        jv = $signed({w[31], w[19:12], w[20], w[30:21], 1'b0});
        uv = {w[31:12], 12'h000};
        e = '0;
        rd1 = 0;
        rd2 = 0;
        case (w[6:0])
            7'b0000011: begin e.op2 = 1; e.wb = 2'b01; e.we = 1; e.mrd = 1; e.imm = iv; rd1 = 1; end
            7'b0100011: begin e.op2 = 1; e.mwr = 1; e.imm = sv; rd1 = 1; rd2 = 1; end
            7'b0010011: begin e.op2 = 1; e.we = 1; e.imm = iv; rd1 = 1; end
            7'b0110011: begin e.we = 1; rd1 = 1; rd2 = 1; end
            7'b1100011: begin e.op1 = 1; e.op2 = 1; e.imm = bv; rd1 = 1; rd2 = 1; end
            7'b0110111: begin e.op2 = 1; e.we = 1; e.imm = uv; end
            7'b0010111: begin e.op1 = 1; e.op2 = 1; e.we = 1; e.imm = uv; end
            7'b1101111: begin e.op1 = 1; e.op2 = 1; e.wb = 2'b10; e.we = 1; e.imm = jv; end
            7'b1100111: begin e.op2 = 1; e.wb = 2'b10; e.we = 1; e.imm = iv; rd1 = 1; end
            default: ;
        endcase
        if (rd1) e.rs1 = w[19:15];
        if (rd2) e.rs2 = w[24:20];
        if (e.we) e.rd = w[11:7];
        return e;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive on the falling edge, compare one half-cycle later past the rising edge
    task automatic apply(logic [31:0] w);
        exp_t e;
        @(negedge clk);
        instr = w;
        @(posedge clk);
        #1;
        e = model(w);
        chk(req_of(w[6:0]), "controls",
            {25'd0, op1_pc, op2_imm, wb_sel, reg_we, mem_rd, mem_wr},
            {25'd0, e.op1, e.op2, e.wb, e.we, e.mrd, e.mwr});
        chk("R12", "indices", {17'd0, rs1_idx, rs2_idx, rd_idx}, {17'd0, e.rs1, e.rs2, e.rd});
        chk("R13", "immediate", imm, e.imm);
        chk("R1", "wb code not 11", {31'd0, wb_sel == 2'b11}, 32'd0);
    endtask

    task automatic lit(string req, string what, logic [31:0] act, logic [31:0] exp);
        chk(req, what, act, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [6:0] ops [9];
        ops = '{7'b0000011, 7'b0100011, 7'b0010011, 7'b0110011, 7'b1100011,
                7'b0110111, 7'b0010111, 7'b1101111, 7'b1100111};

        // R11: all-zero word is an unsupported opcode, everything quiet
        apply(32'h0000_0000);
        lit("R11", "reg_we on zero word", {31'd0, reg_we}, 32'd0);

        // Hand-encoded instructions with literal expectations
        apply(32'h0040a183);  // load x3, 4(x1)
        lit("R2", "load imm", imm, 32'd4);
        lit("R2", "load wb", {30'd0, wb_sel}, 32'd1);
        apply(32'h00a02223);  // store x10, 4(x0)
        lit("R3", "store rs2", {27'd0, rs2_idx}, 32'd10);
        lit("R3", "store mem_wr/reg_we", {30'd0, mem_wr, reg_we}, 32'd2);
        apply(32'h0184f193);  // andi x3, x9, 24
        lit("R4", "opimm imm", imm, 32'd24);
        apply(32'h00415863);  // bge x2, x4, 16
        lit("R6", "branch imm", imm, 32'd16);
        lit("R6", "branch op1 pc", {31'd0, op1_pc}, 32'd1);
        apply(32'hFE208EE3);  // beq x1, x2, -4
        lit("R13", "negative branch imm", imm, 32'hFFFF_FFFC);
        apply(32'h002081b3);  // add x3, x1, x2
        lit("R5", "op selects", {30'd0, op1_pc, op2_imm}, 32'd0);
        apply(32'h000022b7);  // lui x5, 2
        lit("R7", "lui imm", imm, 32'h0000_2000);
        lit("R7", "lui rs1 x0", {27'd0, rs1_idx}, 32'd0);
        apply(32'h008002ef);  // jal x5, 8
        lit("R9", "jal imm", imm, 32'd8);
        lit("R1", "jal wb pc+4", {30'd0, wb_sel}, 32'd2);
        apply(32'hFF9FF06F);  // jal x0, -8
        lit("R13", "negative jal imm", imm, 32'hFFFF_FFF8);
        apply(32'h008082e7);  // jalr x5, x1, 8
        lit("R10", "jalr rs1/op1", {26'd0, rs1_idx, op1_pc}, {26'd0, 5'd1, 1'b0});
        apply(32'h00007117);  // auipc x2, 7
        lit("R8", "auipc imm", imm, 32'h0000_7000);
        apply(32'hFFF00013);  // addi x0, x0, -1
        lit("R13", "negative I imm", imm, 32'hFFFF_FFFF);

        // Pseudo-random words, opcode forced onto each supported value or left free
        for (int i = 0; i < 900; i++) begin
            logic [31:0] w;
            int k;
            w = $urandom;
            k = i % 10;
            if (k < 9) w[6:0] = ops[k];
            apply(w);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule